// File: doc/BRIEF.md
# Streaming Packet Beat-Count and Framing Checker

This block sits passively on a packet-transmit stream between an application and the port that accepts transaction-layer packets. The stream has a data bus, a valid strobe, and start and end markers. The block passes the data, the valid strobe and the markers straight through with no added delay. While it does so, it decodes the first header dword of every packet. From that dword it finds the header size and the payload size, and it works out how many beats the packet must occupy. It counts the beats that are actually sent and sets a sticky error flag when a packet closes at the wrong beat. A second sticky flag is set when the start and end markers arrive in an illegal order.

The bus width is a parameter. At 64 or 128 bits there is one marker bit for each kind, and a beat is the whole bus. At 256 bits the bus is split into two 128-bit halves. Each half has its own start and end marker bit. Bit 0 belongs to data [127:0] and bit 1 belongs to data [255:128]. The half is then the unit that is counted. Half 0 is processed before half 1 in the same cycle, so one packet can close in the lower half while the next one opens in the upper half.

Both flags stay set until reset. A set flag tells the integrator that the downstream port would have stalled on that traffic.

Top module: `tlp_frame_checker`

## Requirements
- R1: out_data, out_valid, out_sop and out_eop equal in_data, in_valid, in_sop and in_eop in the same cycle.
- R2: After reset, frame_err and len_err are both 0.
- R3: In each segment, header dword 0 is segment bits [31:0]. Bit 29 of that dword set means a 4-dword header, and clear means a 3-dword header. Bit 30 set means a payload is present. Bits [9:0] give the payload size in dwords. The expected number of segments is ceil((header dwords + payload dwords) / dwords per segment). A segment is 2 dwords at 64 bits, 4 dwords at 128 bits and 4 dwords at 256 bits. When the end marker comes at exactly that count, no flag is set.
- R4: When the end marker arrives at a segment count different from the expected count, len_err is 1 from the next cycle on.
- R5: A length field of 0 with bit 30 set stands for a 1024-dword payload.
- R6: When bit 30 is clear, the length field has no effect, and the packet is the header alone.
- R7: A start marker in a segment while a packet is still open sets frame_err from the next cycle. The new packet then begins at that segment.
- R8: An end marker in a segment while no packet is open sets frame_err from the next cycle.
- R9: Markers in a cycle with in_valid low are ignored. Such a cycle also does not count as a beat of an open packet.
- R10: In 256-bit mode, half 0 (bits [127:0], marker bit 0) is processed before half 1 (bits [255:128], marker bit 1). A packet may therefore end in half 0 while another starts in half 1 of the same cycle. A half with no open packet and no start marker is idle.
- R11: A segment carrying both a start and an end marker is a one-segment packet, and it is judged against its expected count like any other packet.
- R12: Once set, frame_err and len_err stay 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Packet data from the application |
| in_valid | input | 1 | Beat valid from the application |
| in_sop | input | NSEG | Start marker, one bit per segment |
| in_eop | input | NSEG | End marker, one bit per segment |
| out_data | output | DATA_W | Data forwarded to the transmit port |
| out_valid | output | 1 | Valid forwarded to the transmit port |
| out_sop | output | NSEG | Start markers forwarded |
| out_eop | output | NSEG | End markers forwarded |
| frame_err | output | 1 | Sticky marker-order error |
| len_err | output | 1 | Sticky beat-count error |

## Verification
The internal state of this block is the open flag, the running segment count and the expected count. None of them is visible at the ports. A wrong value surfaces only when the next end or start marker arrives, and it shows as a flag rising one cycle later, or failing to rise. The bench therefore runs a behavioural model in step with the design and compares both flags on every clock. Every packet boundary is then judged in the cycle right after it occurs. The stimulus covers odd and even dword totals, the 1024-dword encoding, idle markers, and back-to-back halves in 256-bit mode.

// File: rtl/tlp_frame_checker.sv
module tlp_frame_checker #(
  parameter int DATA_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_valid,
  input  logic [(DATA_W==256?2:1)-1:0] in_sop,
  input  logic [(DATA_W==256?2:1)-1:0] in_eop,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_valid,
  output logic [(DATA_W==256?2:1)-1:0] out_sop,
  output logic [(DATA_W==256?2:1)-1:0] out_eop,
  output logic                       frame_err,
  output logic                       len_err
);
  localparam int NSEG  = (DATA_W == 256) ? 2 : 1;
  localparam int SEG_W = DATA_W / NSEG;
  localparam int DWPS  = SEG_W / 32;
  localparam int CNT_W = 12;

  assign out_data  = in_data;
  assign out_valid = in_valid;
  assign out_sop   = in_sop;
  assign out_eop   = in_eop;

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, exp_q, exp_d;
  logic             ferr_d, lerr_d;

  function automatic logic [CNT_W-1:0] seg_need(input logic [31:0] h);
    logic [CNT_W-1:0] tot;
    tot = h[29] ? CNT_W'(4) : CNT_W'(3);
    if (h[30]) tot = tot + ((h[9:0] == 10'd0) ? CNT_W'(1024) : CNT_W'(h[9:0]));
    return CNT_W'((tot + CNT_W'(DWPS - 1)) / CNT_W'(DWPS));
  endfunction

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    exp_d  = exp_q;
    ferr_d = frame_err;
    lerr_d = len_err;
    if (in_valid) begin
      for (int s = 0; s < NSEG; s++) begin
        if (in_sop[s]) begin
          if (open_d) ferr_d = 1'b1;
          open_d = 1'b1;
          cnt_d  = CNT_W'(1);
          exp_d  = seg_need(in_data[s*SEG_W +: 32]);
        end else if (open_d && cnt_d != '1) begin
          cnt_d = cnt_d + 1'b1;
        end
        if (in_eop[s]) begin
          if (!open_d) ferr_d = 1'b1;
          else begin
            if (cnt_d != exp_d) lerr_d = 1'b1;
            open_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cnt_q     <= '0;
      exp_q     <= '0;
      frame_err <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      open_q    <= open_d;
      cnt_q     <= cnt_d;
      exp_q     <= exp_d;
      frame_err <= ferr_d;
      len_err   <= lerr_d;
    end
  end
endmodule

module tlp_frame_checker_sva #(
  parameter int NSEG  = 1,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sop0,
  input logic             in_eop0,
  input logic             open_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] exp_q,
  input logic             frame_err,
  input logic             len_err
);
  a_r12_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  a_r12_len_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);
  a_r7_sop_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop0 && open_q) |=> frame_err);
  a_r8_orphan_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop0 && !in_sop0 && !open_q) |=> frame_err);
  a_r4_count_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (NSEG == 1 && in_valid && in_eop0 && !in_sop0 && open_q &&
     CNT_W'(cnt_q + 1'b1) != exp_q) |=> len_err);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !frame_err && !len_err) |=> (!frame_err && !len_err));
endmodule

bind tlp_frame_checker tlp_frame_checker_sva #(.NSEG(NSEG), .CNT_W(CNT_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop0(in_sop[0]),
  .in_eop0(in_eop[0]), .open_q(open_q), .cnt_q(cnt_q), .exp_q(exp_q),
  .frame_err(frame_err), .len_err(len_err));

// File: tb/tlp_frame_checker_tb.sv
module tlp_frame_checker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0]  d64 = '0;
  logic         v64 = 1'b0;
  logic [0:0]   s64 = '0, e64 = '0;
  logic [63:0]  od64;
  logic         ov64, fe64, le64;
  logic [0:0]   os64, oe64;

  logic [255:0] d256 = '0;
  logic         v256 = 1'b0;
  logic [1:0]   s256 = '0, e256 = '0;
  logic [255:0] od256;
  logic         ov256, fe256, le256;
  logic [1:0]   os256, oe256;

  tlp_frame_checker #(.DATA_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(d64), .in_valid(v64), .in_sop(s64), .in_eop(e64),
    .out_data(od64), .out_valid(ov64), .out_sop(os64), .out_eop(oe64),
    .frame_err(fe64), .len_err(le64));

  tlp_frame_checker #(.DATA_W(256)) dut256_i (
    .clk(clk), .rst_n(rst_n), .in_data(d256), .in_valid(v256), .in_sop(s256), .in_eop(e256),
    .out_data(od256), .out_valid(ov256), .out_sop(os256), .out_eop(oe256),
    .frame_err(fe256), .len_err(le256));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model, index 0 = 64-bit, 1 = 256-bit
  bit m_open[2], m_ferr[2], m_lerr[2];
  int m_cnt[2], m_exp[2];

  task automatic model_step(input int m, input logic [255:0] d, input logic v,
                            input logic [1:0] s, input logic [1:0] e,
                            input int nseg, input int dwps);
    if (!v) return;
    for (int k = 0; k < nseg; k++) begin
      logic [31:0] h;
      int tot;
      h = 32'(d >> (k * 32 * dwps));
      if (s[k]) begin
        if (m_open[m]) m_ferr[m] = 1;
        tot = h[29] ? 4 : 3;
        if (h[30]) tot += (h[9:0] == 0) ? 1024 : int'(h[9:0]);
        m_open[m] = 1;
        m_cnt[m]  = 1;
        m_exp[m]  = (tot + dwps - 1) / dwps;
      end else if (m_open[m]) m_cnt[m]++;
      if (e[k]) begin
        if (!m_open[m]) m_ferr[m] = 1;
        else begin
          if (m_cnt[m] != m_exp[m]) m_lerr[m] = 1;
          m_open[m] = 0;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < 2; m++) begin
        m_open[m] = 0; m_ferr[m] = 0; m_lerr[m] = 0; m_cnt[m] = 0; m_exp[m] = 0;
      end
    end else begin
      model_step(0, {192'd0, d64}, v64, {1'b0, s64}, {1'b0, e64}, 1, 2);
      model_step(1, d256, v256, s256, e256, 2, 4);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 passthrough 64", {od64, ov64, os64, oe64}, {d64, v64, s64, e64});
      check("R1 passthrough 256", {od256, ov256, os256, oe256}, {d256, v256, s256, e256});
      check("R4 R7 R8 model flags 64", {fe64, le64}, {m_ferr[0], m_lerr[0]});
      check("R10 R11 model flags 256", {fe256, le256}, {m_ferr[1], m_lerr[1]});
    end
  end

  function automatic logic [31:0] hdr(input bit four, input bit pay, input int len);
    return {1'b0, pay, four, 19'h1a5a5, 10'(len)};
  endfunction

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic pkt64(input logic [31:0] h, input int beats);
    for (int b = 0; b < beats; b++) begin
      @(posedge clk); #1;
      v64 = 1; s64 = (b == 0); e64 = (b == beats - 1);
      d64 = (b == 0) ? {32'hc0de0000, h} : {32'(b), 32'hd00d0000 + 32'(b)};
    end
    @(posedge clk); #1;
    v64 = 0; s64 = 0; e64 = 0; d64 = '0;
  endtask

  task automatic cyc256(input logic [255:0] d, input logic [1:0] s, input logic [1:0] e);
    @(posedge clk); #1;
    v256 = 1; d256 = d; s256 = s; e256 = e;
    @(posedge clk); #1;
    v256 = 0; d256 = '0; s256 = 0; e256 = 0;
  endtask

  task automatic finish_test();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R2 reset flags 64", {fe64, le64}, 2'b00);
    check("R2 reset flags 256", {fe256, le256}, 2'b00);

    pkt64(hdr(0, 0, 5), 2);      // R6: length ignored, 3 dwords -> 2 beats
    @(negedge clk); check("R6 no payload", {fe64, le64}, 2'b00);
    pkt64(hdr(0, 1, 1), 2);      // R3: 4 dwords -> 2 beats
    pkt64(hdr(1, 1, 2), 3);      // R3: 6 dwords -> 3 beats
    pkt64(hdr(0, 1, 4), 4);      // R3: 7 dwords -> 4 beats
    @(negedge clk); check("R3 correct counts", {fe64, le64}, 2'b00);
    pkt64(hdr(0, 1, 0), 514);    // R5: 1027 dwords -> 514 beats
    @(negedge clk); check("R5 length zero 1024", {fe64, le64}, 2'b00);

    @(posedge clk); #1 v64 = 0; s64 = 1; e64 = 1;   // R9: markers without valid
    @(posedge clk); #1 s64 = 0; e64 = 1;
    @(posedge clk); #1 e64 = 0;
    @(negedge clk); check("R9 idle markers ignored", {fe64, le64}, 2'b00);
    @(posedge clk); #1 v64 = 1; s64 = 1; d64 = {32'h0, hdr(0, 1, 1)};
    @(posedge clk); #1 v64 = 0; s64 = 0;            // gap with valid low
    @(posedge clk); #1 v64 = 1; e64 = 1;
    @(posedge clk); #1 v64 = 0; e64 = 0;
    @(negedge clk); check("R9 idle cycle not counted", {fe64, le64}, 2'b00);

    pkt64(hdr(0, 1, 4), 3);      // R4: 4 beats expected, 3 sent
    @(negedge clk); check("R4 short packet", le64, 1'b1);
    pkt64(hdr(0, 1, 1), 2);
    repeat (3) @(posedge clk);
    @(negedge clk); check("R12 len sticky", le64, 1'b1);

    do_reset();
    @(negedge clk); check("R2 flags cleared", {fe64, le64}, 2'b00);
    pkt64(hdr(0, 1, 1), 1);      // R11: single beat, 2 expected
    @(negedge clk); check("R11 single beat 64", {fe64, le64}, 2'b01);

    do_reset();
    @(posedge clk); #1 v64 = 1; s64 = 1; d64 = {32'h0, hdr(0, 1, 1)};
    @(posedge clk); #1 s64 = 1; d64 = {32'h0, hdr(0, 1, 1)};  // R7
    @(posedge clk); #1 s64 = 0; e64 = 1;
    @(posedge clk); #1 v64 = 0; e64 = 0;
    @(negedge clk); check("R7 sop while open", {fe64, le64}, 2'b10);
    repeat (3) @(posedge clk);
    @(negedge clk); check("R12 frame sticky", fe64, 1'b1);

    do_reset();
    @(posedge clk); #1 v64 = 1; e64 = 1;            // R8
    @(posedge clk); #1 v64 = 0; e64 = 0;
    @(negedge clk); check("R8 orphan eop", fe64, 1'b1);

    do_reset();
    // R10: half0 4dw packet complete; half1 opens 8dw packet (2 halves)
    begin
      logic [255:0] d;
      d = '0; d[31:0] = hdr(0, 1, 1); d[159:128] = hdr(1, 1, 4);
      cyc256(d, 2'b11, 2'b01);
      cyc256('0, 2'b00, 2'b01);
      @(negedge clk); check("R10 back-to-back halves", {fe256, le256}, 2'b00);
      d = '0; d[31:0] = hdr(0, 0, 9);                // R11: 3 dwords, 1 half
      cyc256(d, 2'b01, 2'b01);
      @(negedge clk); check("R11 one half packet", {fe256, le256}, 2'b00);
      d = '0; d[159:128] = hdr(0, 1, 10);            // 13 dwords -> 4 halves
      cyc256(d, 2'b10, 2'b00);
      cyc256('0, 2'b00, 2'b10);                      // ends at 3 halves
      @(negedge clk); check("R10 R4 upper half mismatch", {fe256, le256}, 2'b01);
      cyc256('0, 2'b00, 2'b10);
      @(negedge clk); check("R8 orphan eop upper half", fe256, 1'b1);
    end

    repeat (2) @(posedge clk);
    finish_test();
  end
endmodule